// File: doc/BRIEF.md
# Folded Real-by-Complex Mixer

The block mixes two real antenna streams, a main path and a diversity path, with four complex local-oscillator tones. Every input sample is multiplied by the cosine and sine of all four tones, which gives eight complex products, or sixteen scalar products, per sample. The work is folded onto four physical multipliers over a fixed four-slot schedule. One input sample is taken in and then held for four clock cycles. In each slot the block asks the oscillator for that slot's cosine and sine through `lo_sel`.

Samples enter on a valid/ready stream. A sample is taken only when `s_valid` and `s_ready` are both high. `s_ready` is high only in slot 0, and only while the output is not stalled. Results leave on a second valid/ready stream with one beat per slot. Each beat carries an in-phase vector and a quadrature vector, each two lanes wide: lane 0 is main and lane 1 is diversity. It also carries the slot index in `m_chan`, which runs 0,1,2,3 for every sample. When `m_valid` is high and `m_ready` is low, the whole block freezes. The output beat, the slot counter and `lo_sel` all hold, and no new sample is taken. The oscillator must present `lo_cos` and `lo_sin` for the tone `lo_sel` names in the same cycle. Samples are signed with 13 fractional bits, oscillator values are signed with 17 fractional bits, and every product keeps its full 32 bits.

Top module: `fcm_mixer`

## Requirements
- R1: After reset `m_valid` is 0, `s_ready` is 1 and `lo_sel` is 0.
- R2: A sample is taken only in slot 0. In the cycle after a sample is taken, `s_ready` is 0, and it stays low for the three slots that follow.
- R3: While no stall is in force, `lo_sel` counts 0,1,2,3 starting at the cycle a sample is taken. It then returns to 0.
- R4: The beat for slot k carries four products: `m_i` bits [31:0] = main×cos_k, `m_i` bits [63:32] = diversity×cos_k, `m_q` bits [31:0] = main×sin_k and `m_q` bits [63:32] = diversity×sin_k. Each is a 32-bit two's-complement product, exact at the extremes of both operand ranges.
- R5: With no stall, the beat for slot k appears two cycles after the cycle in which `lo_sel` was k. The beats of one sample come on consecutive cycles with `m_chan` equal to 0,1,2,3.
- R6: While `m_valid`=1 and `m_ready`=0, the block holds `m_valid`, `m_chan`, `m_i`, `m_q` and `lo_sel` stable, and `s_ready` is 0.
- R7: Changes on `s_main` and `s_div` during slots 1 to 3 have no effect on that sample's products.
- R8: Samples offered back to back are taken exactly four cycles apart, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample (slot 0, not stalled) |
| s_main | input | 14 | Main antenna sample, signed |
| s_div | input | 14 | Diversity antenna sample, signed |
| lo_sel | output | 2 | Tone index requested from the oscillator |
| lo_cos | input | 18 | Cosine of tone `lo_sel`, signed |
| lo_sin | input | 18 | Sine of tone `lo_sel`, signed |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_chan | output | 2 | Tone index of the current beat |
| m_i | output | 64 | In-phase products, lane 1 in the upper half |
| m_q | output | 64 | Quadrature products, lane 1 in the upper half |

## Verification
A slot counter that is out of step with the data shows up in the first beat of a sample. The products then pair a sample with the wrong tone, or `m_chan` skips a value, and this happens within two cycles. If the hold register is corrupt or not loaded, slots 1 to 3 carry products of the wrong sample. Live input values that change on purpose during those slots expose this at once. A stall signal that does not freeze every stage changes the held beat, or it loses or repeats a beat. The ordered scoreboard reports this at the next handshake.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int DATA_W    = 14;
  localparam int LO_W      = 18;
  localparam int NUM_SLOTS = 4;
  localparam int NUM_ANT   = 2;
  localparam int MUL_LAT   = 2;
endpackage

// File: rtl/fcm_sched.sv
module fcm_sched #(
  parameter int DATA_W    = 14,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_main,
  input  logic [DATA_W-1:0] s_div,
  output logic              iss_valid,
  output logic [SLOT_W-1:0] iss_slot,
  output logic [DATA_W-1:0] iss_main,
  output logic [DATA_W-1:0] iss_div
);
  logic [SLOT_W-1:0] slot_q;
  logic [DATA_W-1:0] hold_main, hold_div;
  logic              take;

  assign s_ready   = adv && (slot_q == '0);
  assign take      = s_valid && s_ready;
  assign iss_valid = (slot_q != '0) || s_valid;
  assign iss_slot  = slot_q;
  assign iss_main  = (slot_q == '0) ? s_main : hold_main;
  assign iss_div   = (slot_q == '0) ? s_div  : hold_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= '0;
      hold_main <= '0;
      hold_div  <= '0;
    end else if (adv) begin
      if (take || slot_q != '0) slot_q <= slot_q + SLOT_W'(1);
      if (take) begin
        hold_main <= s_main;
        hold_div  <= s_div;
      end
    end
  end

  // R2
  acc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && slot_q != '0) |=> (slot_q == SLOT_W'($past(slot_q) + SLOT_W'(1))));
endmodule

// File: rtl/fcm_mul_lane.sv
module fcm_mul_lane #(
  parameter int A_W = 14,
  parameter int B_W = 18,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] p
);
  logic signed [A_W-1:0] a_r;
  logic signed [B_W-1:0] b_r;
  logic signed [P_W-1:0] p_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r <= '0;
      b_r <= '0;
      p_r <= '0;
    end else if (en) begin
      a_r <= a;
      b_r <= b;
      p_r <= a_r * b_r;
    end
  end

  assign p = p_r;
endmodule

// File: rtl/fcm_tag_pipe.sv
module fcm_tag_pipe #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] in_tag,
  output logic         out_valid,
  output logic [W-1:0] out_tag
);
  logic [DEPTH-1:0] vld;
  logic [W-1:0]     tag [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic         nv;
    logic [W-1:0] nt;
    if (i == 0) begin : g_head
      assign nv = in_valid;
      assign nt = in_tag;
    end else begin : g_body
      assign nv = vld[i-1];
      assign nt = tag[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        tag[i] <= '0;
      end else if (en) begin
        vld[i] <= nv;
        tag[i] <= nt;
      end
    end
  end

  assign out_valid = vld[DEPTH-1];
  assign out_tag   = tag[DEPTH-1];
endmodule

// File: rtl/fcm_mixer.sv
module fcm_mixer #(
  parameter int DATA_W    = fcm_pkg::DATA_W,
  parameter int LO_W      = fcm_pkg::LO_W,
  parameter int NUM_SLOTS = fcm_pkg::NUM_SLOTS,
  localparam int PROD_W   = DATA_W + LO_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int NUM_MUL  = 2 * fcm_pkg::NUM_ANT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [DATA_W-1:0]     s_main,
  input  logic [DATA_W-1:0]     s_div,
  output logic [SLOT_W-1:0]     lo_sel,
  input  logic [LO_W-1:0]       lo_cos,
  input  logic [LO_W-1:0]       lo_sin,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [SLOT_W-1:0]     m_chan,
  output logic [2*PROD_W-1:0]   m_i,
  output logic [2*PROD_W-1:0]   m_q
);
  logic              adv;
  logic              iss_valid;
  logic [SLOT_W-1:0] iss_slot;
  logic [DATA_W-1:0] iss_main, iss_div;
  logic [PROD_W-1:0] prod [NUM_MUL];

  assign adv    = !(m_valid && !m_ready);
  assign lo_sel = iss_slot;

  fcm_sched #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_sched (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .s_valid(s_valid), .s_ready(s_ready), .s_main(s_main), .s_div(s_div),
    .iss_valid(iss_valid), .iss_slot(iss_slot),
    .iss_main(iss_main), .iss_div(iss_div)
  );

  // lane j: antenna = j/2 (0 main, 1 diversity), phase = j%2 (0 cos, 1 sin)
  for (genvar j = 0; j < NUM_MUL; j++) begin : g_lane
    logic [DATA_W-1:0] a_sel;
    logic [LO_W-1:0]   b_sel;
    assign a_sel = (j / 2 == 0) ? iss_main : iss_div;
    assign b_sel = (j % 2 == 0) ? lo_cos : lo_sin;
    fcm_mul_lane #(.A_W(DATA_W), .B_W(LO_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .a(a_sel), .b(b_sel), .p(prod[j])
    );
  end

  fcm_tag_pipe #(.W(SLOT_W), .DEPTH(fcm_pkg::MUL_LAT)) u_tag (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_valid(iss_valid), .in_tag(iss_slot),
    .out_valid(m_valid), .out_tag(m_chan)
  );

  assign m_i = {prod[2], prod[0]};
  assign m_q = {prod[3], prod[1]};

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_chan) && $stable(m_i)
                               && $stable(m_q) && $stable(lo_sel)));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R5
  chan_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_chan != {SLOT_W{1'b1}})
      |=> (m_valid && m_chan == SLOT_W'($past(m_chan) + SLOT_W'(1))));
endmodule

// File: tb/fcm_mixer_bench.sv
module fcm_mixer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [13:0] s_main = '0, s_div = '0;
  logic [1:0] lo_sel;
  logic signed [17:0] lo_cos, lo_sin;
  logic m_valid;
  logic m_ready = 1'b1;
  logic [1:0] m_chan;
  logic [63:0] m_i, m_q;

  always #5 clk = ~clk;

  fcm_mixer u_fcm_mixer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_main(s_main), .s_div(s_div), .lo_sel(lo_sel), .lo_cos(lo_cos),
    .lo_sin(lo_sin), .m_valid(m_valid), .m_ready(m_ready), .m_chan(m_chan),
    .m_i(m_i), .m_q(m_q)
  );

  logic signed [17:0] cos_tab [4];
  logic signed [17:0] sin_tab [4];
  assign lo_cos = cos_tab[lo_sel];
  assign lo_sin = sin_tab[lo_sel];

  typedef struct { int chan; int i0; int i1; int q0; int q1; } beat_t;
  beat_t exp_q[$];

  int checks = 0, failures = 0, cyc = 0, acc_cyc = 0;
  bit stall_mode = 0, prev_hold = 0;
  logic [1:0] h_chan, h_sel;
  logic [63:0] h_i, h_q;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: called just after a rising edge; returns just after the accepting edge
  task automatic send(input int mn, input int dv);
    s_valid = 1'b1;
    s_main = 14'(mn);
    s_div = 14'(dv);
    @(negedge clk);
    while (!s_ready) begin
      @(posedge clk); #1;
      @(negedge clk);
    end
    @(posedge clk);
    acc_cyc = cyc;
    for (int k = 0; k < 4; k++) begin
      beat_t b;
      b.chan = k;
      b.i0 = mn * int'(cos_tab[k]);
      b.i1 = dv * int'(cos_tab[k]);
      b.q0 = mn * int'(sin_tab[k]);
      b.q1 = dv * int'(sin_tab[k]);
      exp_q.push_back(b);
    end
    #1;
    s_valid = 1'b0;
    s_main = 14'($urandom);  // R7: junk while the sample is held
    s_div = 14'($urandom);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) begin
        chk(m_valid && m_chan == h_chan && m_i == h_i && m_q == h_q && lo_sel == h_sel,
            "R6 hold", longint'(m_chan), longint'(h_chan));
      end
      if (m_valid && !m_ready) chk(!s_ready, "R6 ready low", longint'(s_ready), 0);
      prev_hold = m_valid && !m_ready;
      h_chan = m_chan; h_i = m_i; h_q = m_q; h_sel = lo_sel;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected beat", longint'(m_chan), -1);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(int'(m_chan) == e.chan, "R5 chan", longint'(m_chan), e.chan);
          chk($signed(m_i[31:0]) == e.i0 && $signed(m_i[63:32]) == e.i1,
              "R4 R7 in-phase", longint'($signed(m_i[31:0])), e.i0);
          chk($signed(m_q[31:0]) == e.q0 && $signed(m_q[63:32]) == e.q1,
              "R4 R7 quadrature", longint'($signed(m_q[31:0])), e.q0);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      m_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int a0, a1, a2, w;
    cos_tab[0] = 18'sd131071;  sin_tab[0] = 18'sd0;
    cos_tab[1] = -18'sd131072; sin_tab[1] = 18'sd131071;
    cos_tab[2] = 18'sd40000;   sin_tab[2] = -18'sd131072;
    cos_tab[3] = -18'sd77;     sin_tab[3] = 18'sd91234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_valid == 0, "R1 m_valid", longint'(m_valid), 0);
    chk(s_ready == 1, "R1 s_ready", longint'(s_ready), 1);
    chk(lo_sel == 0, "R1 lo_sel", longint'(lo_sel), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // latency and slot order
    send(1000, -500);
    @(negedge clk);
    chk(m_valid == 0, "R5 latency early", longint'(m_valid), 0);
    chk(lo_sel == 1, "R3 slot1", longint'(lo_sel), 1);
    chk(s_ready == 0, "R2 busy", longint'(s_ready), 0);
    @(negedge clk);
    chk(m_valid == 1 && m_chan == 0, "R5 latency first beat", longint'(m_valid), 1);
    chk(lo_sel == 2, "R3 slot2", longint'(lo_sel), 2);
    chk(s_ready == 0, "R2 busy2", longint'(s_ready), 0);
    @(negedge clk);
    chk(lo_sel == 3, "R3 slot3", longint'(lo_sel), 3);
    chk(s_ready == 0, "R2 busy3", longint'(s_ready), 0);
    @(negedge clk);
    chk(lo_sel == 0, "R3 wrap", longint'(lo_sel), 0);
    repeat (4) @(posedge clk);
    #1;

    // corners, back to back
    send(-8192, 8191); a0 = acc_cyc;
    send(8191, -8192); a1 = acc_cyc;
    send(0, -1);       a2 = acc_cyc;
    chk(a1 - a0 == 4, "R8 gap1", a1 - a0, 4);
    chk(a2 - a1 == 4, "R8 gap2", a2 - a1, 4);

    // random back-pressure
    stall_mode = 1;
    for (int n = 0; n < 40; n++) send($urandom % 16384 - 8192, $urandom % 16384 - 8192);
    stall_mode = 0;
    w = 0;
    while (exp_q.size() != 0 && w < 400) begin
      @(posedge clk); w++;
    end
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule